// File: doc/BRIEF.md
# Three-Channel Programmable Interval Timer

This block holds three independent 16-bit down-counters behind a byte-wide register port with a 2-bit address. Offsets 0 to 2 reach the counters' data registers and offset 3 takes control words, which set a channel's mode and byte-access order or ask for a snapshot of one or more channels. A shared count-enable input paces all counting, and each channel has its own gate input and output pin.

Each channel runs one of three modes: a one-shot that raises its output at terminal count, a free-running square wave, and a single-tick strobe started by software. The host loads an initial count one byte at a time. To read a running count without tearing, the host freezes it first, then reads it as bytes while counting goes on. A read-back control word can freeze count, status or both on several channels in a single write.

Top module: `interval_timer_set`

## Requirements
- R1: A write to offset 3 with bits 7:6 equal to 0, 1 or 2 addresses that channel. A nonzero access field (bits 5:4) then reprograms the channel: access field, mode field (bits 3:1) and output level are set, counting halts and the byte pointers go back to the low byte. Offsets 0, 1 and 2 reach the data registers of channels 0, 1 and 2.
- R2: Access field 01 makes each data write a low byte with the high byte cleared. Access field 10 makes each data write a high byte with the low byte cleared. Access field 11 takes a low byte and then a high byte. Reads follow the same order.
- R3: A count takes effect on the first enabled clock after its last byte is written, whatever the gate level. The null-count flag is set by reprogramming or by a completed count write, and clears at that load.
- R4: Mode 000 (terminal count): the output goes low when the channel is programmed. It goes high on the Nth enabled, gated clock after the load and stays high.
- R5: Mode 011 (square wave): the output goes high at load. The count falls by two per enabled, gated clock and the output toggles each time the count runs out, so the period is N clocks. Bit 0 of an odd N is ignored.
- R6: Mode 100 (strobe): the output is high. On the Nth enabled, gated clock after the load it goes low for exactly one enabled clock, and this happens once per count written.
- R7: An initial count of 0 acts as 65536 in every mode.
- R8: A channel's count does not change while its gate input is low.
- R9: A control word with access field 00 freezes that channel's count. The reads that follow return the frozen bytes in the channel's byte order while the live count keeps running.
- R10: While a frozen count or status byte is still unread, further freeze requests of that kind for that channel are ignored.
- R11: A control word with bits 7:6 = 11 is a read-back. Bit 5 = 0 freezes the count and bit 4 = 0 freezes the status of every channel whose select bit is set (bit 1 for channel 0, bit 2 for channel 1, bit 3 for channel 2). A frozen status byte is read before a frozen count.
- R12: The status byte holds the output level in bit 7 and the null-count flag in bit 6. Bits 5:0 hold the access field, the mode field and a zero.
- R13: After reset every output is low, nothing is frozen, and every channel reports status 0x00 and count 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Count enable shared by all channels |
| bus_addr | input | 2 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; advances the selected channel's read sequence |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while bus_rd is high |
| gate_in | input | NUM_CH | Per-channel gate |
| tmr_out | output | NUM_CH | Per-channel output |

## Verification
The hardest case to reach is a frozen count that stays stable while the live counter keeps moving, with a second freeze request landing halfway through a two-byte read. The stimulus counts clock edges from the final data byte, so it knows the exact value each freeze captures. It inserts the ignored request between the low and high reads, then freezes again once the read is complete and expects a value lower by the number of edges in between. A read-back across two channels is checked with their gates held low so both counts sit still, and the gate is released later to time the first square-wave toggle to the exact edge.

// File: rtl/pit_pkg.sv
package pit_pkg;

   localparam logic [2:0] MODE_TC  = 3'b000;
   localparam logic [2:0] MODE_SQ  = 3'b011;
   localparam logic [2:0] MODE_STB = 3'b100;

   localparam logic [1:0] ACC_FRZ  = 2'b00;
   localparam logic [1:0] ACC_LO   = 2'b01;
   localparam logic [1:0] ACC_HI   = 2'b10;
   localparam logic [1:0] ACC_LOHI = 2'b11;

   typedef struct packed {
      logic prog;
      logic frz_cnt;
      logic frz_st;
      logic data_wr;
      logic rd_stb;
   } ch_cmd_t;

endpackage

// File: rtl/pit_cmd_decode.sv
module pit_cmd_decode
   import pit_pkg::*;
#(
   parameter int NUM_CH = 3
) (
   input  logic                    wr,
   input  logic                    rd,
   input  logic [1:0]              addr,
   input  logic [7:0]              wdata,
   output ch_cmd_t [NUM_CH-1:0]    cmd
);

   localparam logic [1:0] CTL_ADDR = 2'd3;

   logic ctl_wr;
   logic rb_cmd;

   assign ctl_wr = wr && (addr == CTL_ADDR);
   assign rb_cmd = (wdata[7:6] == 2'b11);

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      logic hit;
      logic rb_sel;
      assign hit    = ctl_wr && !rb_cmd && (wdata[7:6] == 2'(i));
      assign rb_sel = ctl_wr && rb_cmd && wdata[1+i];
      always_comb begin
         cmd[i].prog    = hit && (wdata[5:4] != ACC_FRZ);
         cmd[i].frz_cnt = (hit && (wdata[5:4] == ACC_FRZ)) || (rb_sel && !wdata[5]);
         cmd[i].frz_st  = rb_sel && !wdata[4];
         cmd[i].data_wr = wr && (addr == 2'(i));
         cmd[i].rd_stb  = rd && (addr == 2'(i));
      end
   end

endmodule

// File: rtl/pit_channel.sv
module pit_channel
   import pit_pkg::*;
#(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              gate,
   input  ch_cmd_t           cmd,
   input  logic [5:0]        cfg,
   input  logic [BYTE_W-1:0] wdata,
   output logic [BYTE_W-1:0] rd_byte,
   output logic              out_lvl
);

   localparam int CNT_W = 2 * BYTE_W;

   logic [1:0]       acc_q;
   logic [2:0]       mode_q;
   logic [CNT_W-1:0] cr_q, cnt_q, frz_val_q;
   logic [BYTE_W-1:0] st_val_q;
   logic out_q, null_q, load_pend_q, run_q, armed_q, stb_low_q;
   logic wr_hi_q, rd_hi_q, frz_q, st_q;

   logic is_sq, is_stb, wr_done, counting;
   logic [CNT_W-1:0] cr_nxt, sq_reload, rd_src;

   assign is_sq     = (mode_q == MODE_SQ);
   assign is_stb    = (mode_q == MODE_STB);
   assign sq_reload = {cr_q[CNT_W-1:1], 1'b0};
   assign counting  = tick && run_q && gate && !load_pend_q;
   assign wr_done   = cmd.data_wr &&
                      ((acc_q == ACC_LO) || (acc_q == ACC_HI) ||
                       ((acc_q == ACC_LOHI) && wr_hi_q));

   always_comb begin
      cr_nxt = cr_q;
      unique case (acc_q)
         ACC_LO:   cr_nxt = {{BYTE_W{1'b0}}, wdata};
         ACC_HI:   cr_nxt = {wdata, {BYTE_W{1'b0}}};
         ACC_LOHI: cr_nxt = wr_hi_q ? {wdata, cr_q[BYTE_W-1:0]}
                                    : {cr_q[CNT_W-1:BYTE_W], wdata};
         default:  cr_nxt = cr_q;
      endcase
   end

   always_comb begin
      rd_src = frz_q ? frz_val_q : cnt_q;
      if (st_q)
         rd_byte = st_val_q;
      else if ((acc_q == ACC_HI) || ((acc_q == ACC_LOHI) && rd_hi_q))
         rd_byte = rd_src[CNT_W-1:BYTE_W];
      else
         rd_byte = rd_src[BYTE_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q       <= ACC_FRZ;
         mode_q      <= MODE_TC;
         cr_q        <= '0;
         cnt_q       <= '0;
         frz_val_q   <= '0;
         st_val_q    <= '0;
         out_q       <= 1'b0;
         null_q      <= 1'b0;
         load_pend_q <= 1'b0;
         run_q       <= 1'b0;
         armed_q     <= 1'b0;
         stb_low_q   <= 1'b0;
         wr_hi_q     <= 1'b0;
         rd_hi_q     <= 1'b0;
         frz_q       <= 1'b0;
         st_q        <= 1'b0;
      end else begin
         // counting element
         if (tick && load_pend_q) begin
            cnt_q       <= is_sq ? sq_reload : cr_q;
            load_pend_q <= 1'b0;
            null_q      <= 1'b0;
            run_q       <= 1'b1;
            armed_q     <= 1'b1;
            if (is_sq) out_q <= 1'b1;
         end else begin
            if (tick && is_stb && stb_low_q) begin
               out_q     <= 1'b1;
               stb_low_q <= 1'b0;
            end
            if (counting) begin
               if (is_sq) begin
                  if (cnt_q == CNT_W'(2)) begin
                     cnt_q <= sq_reload;
                     out_q <= ~out_q;
                  end else begin
                     cnt_q <= cnt_q - CNT_W'(2);
                  end
               end else begin
                  cnt_q <= cnt_q - CNT_W'(1);
                  if ((cnt_q == CNT_W'(1)) && armed_q) begin
                     armed_q <= 1'b0;
                     if (is_stb) begin
                        out_q     <= 1'b0;
                        stb_low_q <= 1'b1;
                     end else begin
                        out_q <= 1'b1;
                     end
                  end
               end
            end
         end
         // host data writes
         if (cmd.data_wr) begin
            cr_q <= cr_nxt;
            if (acc_q == ACC_LOHI) wr_hi_q <= ~wr_hi_q;
         end
         if (wr_done) begin
            load_pend_q <= 1'b1;
            null_q      <= 1'b1;
            if (mode_q == MODE_TC) out_q <= 1'b0;
         end
         // host reads
         if (cmd.rd_stb) begin
            if (st_q) begin
               st_q <= 1'b0;
            end else begin
               if (acc_q == ACC_LOHI) rd_hi_q <= ~rd_hi_q;
               if (frz_q && ((acc_q != ACC_LOHI) || rd_hi_q)) frz_q <= 1'b0;
            end
         end
         // snapshots
         if (cmd.frz_cnt && !frz_q) begin
            frz_q     <= 1'b1;
            frz_val_q <= cnt_q;
         end
         if (cmd.frz_st && !st_q) begin
            st_q     <= 1'b1;
            st_val_q <= {out_q, null_q, acc_q, mode_q, 1'b0};
         end
         // reprogramming overrides everything
         if (cmd.prog) begin
            acc_q       <= cfg[5:4];
            mode_q      <= cfg[3:1];
            out_q       <= (cfg[3:1] != MODE_TC);
            null_q      <= 1'b1;
            load_pend_q <= 1'b0;
            run_q       <= 1'b0;
            armed_q     <= 1'b0;
            stb_low_q   <= 1'b0;
            wr_hi_q     <= 1'b0;
            rd_hi_q     <= 1'b0;
         end
      end
   end

   assign out_lvl = out_q;

   // R3
   null_clear_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(null_q) |-> $past(tick));

   // R9
   frozen_count_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frz_q && $past(frz_q)) |-> (frz_val_q == $past(frz_val_q)));

   // R6
   strobe_one_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_stb && !out_q && stb_low_q && tick && !cmd.prog) |=> out_q);

   // R4
   tc_rise_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(out_q) && ($past(mode_q) == MODE_TC) && !$past(cmd.prog)) |-> $past(tick));

endmodule

// File: rtl/interval_timer_set.sv
module interval_timer_set
   import pit_pkg::*;
#(
   parameter int NUM_CH = 3,
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic [1:0]        bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   input  logic [NUM_CH-1:0] gate_in,
   output logic [NUM_CH-1:0] tmr_out
);

   localparam int MAX_CH = 3;

   initial begin
      assert (BYTE_W == 8) else $error("interval_timer_set: BYTE_W must be 8");
      assert (NUM_CH >= 1 && NUM_CH <= MAX_CH) else $error("interval_timer_set: NUM_CH out of range");
   end

   ch_cmd_t [NUM_CH-1:0] cmd;
   logic [BYTE_W-1:0] ch_rd [NUM_CH];

   pit_cmd_decode #(.NUM_CH(NUM_CH)) u_dec (
      .wr    (bus_wr),
      .rd    (bus_rd),
      .addr  (bus_addr),
      .wdata (bus_wdata),
      .cmd   (cmd)
   );

   for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
      pit_channel #(.BYTE_W(BYTE_W)) u_ch (
         .clk     (clk),
         .rst_n   (rst_n),
         .tick    (tick_en),
         .gate    (gate_in[i]),
         .cmd     (cmd[i]),
         .cfg     (bus_wdata[5:0]),
         .wdata   (bus_wdata),
         .rd_byte (ch_rd[i]),
         .out_lvl (tmr_out[i])
      );
   end

   always_comb begin
      bus_rdata = '0;
      for (int i = 0; i < NUM_CH; i++)
         if (bus_rd && (bus_addr == 2'(i))) bus_rdata = ch_rd[i];
   end

endmodule

// File: tb/interval_timer_set_test.sv
module interval_timer_set_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_en = 1'b1;
   logic [1:0] bus_addr = '0;
   logic       bus_wr = 1'b0;
   logic       bus_rd = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic [2:0] gate_in = 3'b111;
   logic [2:0] tmr_out;

   int n_chk = 0;
   int n_bad = 0;

   interval_timer_set uut (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_addr(bus_addr),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .gate_in(gate_in), .tmr_out(tmr_out)
   );

   always #5 clk = ~clk;

   // {acc[1:0], mode[2:0], count[15:0], first[16:0], second[15:0]}
   localparam logic [53:0] VEC [10] = '{
      {2'd3, 3'd0, 16'd3,   17'd4,     16'd0},
      {2'd3, 3'd3, 16'd4,   17'd3,     16'd2},
      {2'd3, 3'd3, 16'd6,   17'd4,     16'd3},
      {2'd3, 3'd3, 16'd5,   17'd3,     16'd2},
      {2'd3, 3'd4, 16'd2,   17'd3,     16'd1},
      {2'd3, 3'd4, 16'd7,   17'd8,     16'd1},
      {2'd1, 3'd0, 16'd9,   17'd10,    16'd0},
      {2'd2, 3'd0, 16'd256, 17'd257,   16'd0},
      {2'd3, 3'd0, 16'd0,   17'd65537, 16'd0},
      {2'd3, 3'd3, 16'd0,   17'd32769, 16'd0}
   };

   task automatic chk(input logic ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // entered at a falling edge, consumes exactly one rising edge
   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      bus_addr = a; bus_rd = 1'b1;
      #2 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic rd_chk(input logic [1:0] a, input logic [7:0] exp, input string tag);
      logic [7:0] v;
      rd(a, v);
      chk(v == exp, tag, v, exp);
   endtask

   task automatic run_vec(input logic [53:0] v);
      logic [1:0]  acc;
      logic [2:0]  mode;
      logic [15:0] cnt;
      int first, second, k;
      logic lvl;
      acc = v[53:52]; mode = v[51:49]; cnt = v[48:33];
      first = int'(v[32:16]); second = int'(v[15:0]);
      wr(2'd3, {2'b00, acc, mode, 1'b0});
      chk(tmr_out[0] == (mode != 3'd0), "R1 R4 R5 R6 level after program", tmr_out[0], mode != 3'd0);
      if (acc == 2'd1) wr(2'd0, cnt[7:0]);
      else if (acc == 2'd2) wr(2'd0, cnt[15:8]);
      else begin wr(2'd0, cnt[7:0]); wr(2'd0, cnt[15:8]); end
      lvl = tmr_out[0];
      k = 0;
      while (tmr_out[0] == lvl && k < first + 4) begin
         @(negedge clk); k++;
      end
      chk(k == first, (mode == 3'd3) ? "R5 R7 first toggle" : (mode == 3'd4) ? "R6 strobe edge" : "R2 R4 R7 terminal count", k, first);
      lvl = tmr_out[0];
      if (second != 0) begin
         k = 0;
         while (tmr_out[0] == lvl && k < second + 4) begin
            @(negedge clk); k++;
         end
         chk(k == second, (mode == 3'd3) ? "R5 half period" : "R6 strobe width", k, second);
      end else begin
         k = 0;
         for (int j = 0; j < 20; j++) begin
            @(negedge clk);
            if (tmr_out[0] != lvl) k++;
         end
         chk(k == 0, "R4 output holds", k, 0);
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // reset state
      chk(tmr_out == 3'b000, "R13 outputs low", tmr_out, 0);
      wr(2'd3, 8'hEE);
      rd_chk(2'd0, 8'h00, "R13 status ch0");
      rd_chk(2'd1, 8'h00, "R13 status ch1");
      rd_chk(2'd2, 8'h00, "R13 status ch2");
      wr(2'd3, 8'h00);
      rd_chk(2'd0, 8'h00, "R13 count ch0");

      // table of mode / count vectors on channel 0
      for (int i = 0; i < 10; i++) run_vec(VEC[i]);

      // frozen count on channel 2
      wr(2'd3, 8'hB0);
      wr(2'd2, 8'h34);
      wr(2'd2, 8'h12);
      repeat (10) @(negedge clk);
      wr(2'd3, 8'h80);
      repeat (3) @(negedge clk);
      rd_chk(2'd2, 8'h2B, "R9 frozen low byte");
      wr(2'd3, 8'h80);
      rd_chk(2'd2, 8'h12, "R10 second freeze ignored");
      wr(2'd3, 8'h80);
      rd_chk(2'd2, 8'h24, "R9 count kept running low");
      rd_chk(2'd2, 8'h12, "R9 count kept running high");

      // read-back across channels with gates low
      gate_in[1:0] = 2'b00;
      wr(2'd3, 8'h10);
      wr(2'd0, 8'h05);
      repeat (2) @(negedge clk);
      wr(2'd3, 8'h76);
      wr(2'd3, 8'hE4);
      rd_chk(2'd1, 8'hF6, "R12 R3 status with null count");
      wr(2'd1, 8'h10);
      wr(2'd1, 8'h00);
      repeat (3) @(negedge clk);
      chk(tmr_out[1:0] == 2'b10, "R8 outputs while gated off", tmr_out[1:0], 2);
      wr(2'd3, 8'hD6);
      rd_chk(2'd0, 8'h05, "R11 R8 ch0 count");
      rd_chk(2'd1, 8'h10, "R11 R8 ch1 count low");
      rd_chk(2'd1, 8'h00, "R11 ch1 count high");
      wr(2'd3, 8'hC6);
      rd_chk(2'd1, 8'hB6, "R11 R12 ch1 status first");
      rd_chk(2'd1, 8'h10, "R11 ch1 count low after status");
      rd_chk(2'd1, 8'h00, "R11 ch1 count high after status");
      rd_chk(2'd0, 8'h10, "R11 R12 ch0 status first");
      rd_chk(2'd0, 8'h05, "R11 R2 ch0 count");

      // release gate on channel 1
      gate_in[1] = 1'b1;
      repeat (7) @(negedge clk);
      chk(tmr_out[1] == 1'b1, "R8 R5 before toggle", tmr_out[1], 1);
      @(negedge clk);
      chk(tmr_out[1] == 1'b0, "R8 R5 toggle after gate", tmr_out[1], 0);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule